// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Register

This block carries a single 36-bit word from a writer clock domain to a reader clock domain without passing it through a FIFO. The writer offers a word with a valid/ready handshake. An accepted word is captured in a holding register, and the active-low mailbox flag in the writer domain drops. The flag stays low until the reader has taken the word. The two clocks may be unrelated, or they may share rising edges.

The reader side sees an availability signal once the write event has crossed into its domain. The reader performs a read with the mailbox select high, and that read sends an acknowledge back to the writer, which raises the flag again. The reader's data port is shared with a FIFO output register that this block receives as an input bus. The same select line chooses whether the port returns the mailbox word or the FIFO word.

Back-pressure rules on the write side:
- `wr_ready` is the flag itself.
- A word is taken only on a writer edge where `wr_valid` and `wr_ready` are both high.
- A word offered while `wr_ready` is low is dropped and leaves no trace.
- Nothing needs to be held stable between offers.

Top module: `mbox_bypass`

## Requirements
- R1: While master reset (`mrst_n` low) is applied, and after it is released, `mbf_n` and `wr_ready` are 1 and `rd_avail` is 0. The holding register reads back as all zeros on `rd_q` when `rd_mbsel` is 1.
- R2: A writer-clock rising edge with `wr_valid` and `wr_ready` both high captures `wr_data` and drives `mbf_n` to 0 after that edge.
- R3: A word offered while `mbf_n` is 0 is ignored. The held word seen by the reader is unchanged.
- R4: After an accepted write, `rd_avail` rises within four reader-clock edges. While `rd_avail` is 1, `mbf_n` is 0.
- R5: A reader-clock rising edge with `rd_en`, `rd_mbsel` and `rd_avail` all 1 takes the word. `rd_avail` drops after that edge, and `mbf_n` returns to 1 within four writer-clock edges.
- R6: A reader edge with `rd_en` low, or with `rd_mbsel` low, does not take the word. `rd_avail` stays 1.
- R7: `rd_q` equals the held word when `rd_mbsel` is 1 and equals `fifo_q` when `rd_mbsel` is 0.
- R8: Partial reset (`prst_n` low) forces `mbf_n` to 1 and `rd_avail` to 0. It keeps the held word.
- R9: While `mbf_n` is 0, the held word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Writer clock |
| clk_r | input | 1 | Reader clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous; clears flag and word |
| prst_n | input | 1 | Partial reset, active low, asynchronous; clears flag, keeps word |
| wr_valid | input | 1 | Writer offers `wr_data` |
| wr_ready | output | 1 | Mailbox can take a word (equals `mbf_n`) |
| wr_data | input | 36 | Word to post |
| mbf_n | output | 1 | Mailbox flag, low while a word is held and not yet taken |
| rd_en | input | 1 | Reader performs a read this edge |
| rd_mbsel | input | 1 | 1 selects mailbox, 0 selects FIFO output register |
| fifo_q | input | 36 | FIFO output register contents |
| rd_avail | output | 1 | A posted word has reached the reader domain |
| rd_q | output | 36 | Read data port |

## Verification
A toggle that is lost or duplicated in either direction shows up at the ports as a wrong flag state. Either `mbf_n` stays low for good after a read, or `rd_avail` rises a second time for a word that was already taken. Either fault becomes visible within about four edges of the receiving clock. A holding register that updates while the flag is low gives the reader a word other than the first one accepted. The scoreboard reports this on the very next mailbox read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_W_DEF = 36;
  localparam int unsigned SYNC_DEF   = 2;
  typedef enum logic {RSEL_FIFO = 1'b0, RSEL_MBOX = 1'b1} rsel_e;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_wr_side.sv
module mbox_wr_side #(
  parameter int unsigned W    = 36,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk_w,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         ack_tog,
  output logic         mbf_n,
  output logic         req_tog,
  output logic [W-1:0] word_q
);
  logic rst_n;
  logic ack_s;
  logic take;

  assign rst_n = mrst_n & prst_n;

  mbox_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk(clk_w), .rst_n(rst_n), .d(ack_tog), .q(ack_s)
  );

  // Flag is high when every posted word has been acknowledged
  assign mbf_n = (req_tog == ack_s);
  assign take  = wr_valid & mbf_n & rst_n;

  always_ff @(posedge clk_w or negedge rst_n)
    if (!rst_n)    req_tog <= 1'b0;
    else if (take) req_tog <= ~req_tog;

  // Word survives partial reset, cleared only by master reset
  always_ff @(posedge clk_w or negedge mrst_n)
    if (!mrst_n)   word_q <= '0;
    else if (take) word_q <= wr_data;
endmodule

// File: rtl/mbox_rd_side.sv
module mbox_rd_side #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_r,
  input  logic mrst_n,
  input  logic prst_n,
  input  logic req_tog,
  input  logic rd_en,
  input  logic rd_mbsel,
  output logic rd_avail,
  output logic ack_tog
);
  logic rst_n;
  logic req_s;

  assign rst_n = mrst_n & prst_n;

  mbox_sync #(.STAGES(SYNC)) u_req_sync (
    .clk(clk_r), .rst_n(rst_n), .d(req_tog), .q(req_s)
  );

  assign rd_avail = (req_s != ack_tog);

  always_ff @(posedge clk_r or negedge rst_n)
    if (!rst_n)                            ack_tog <= 1'b0;
    else if (rd_en && rd_mbsel && rd_avail) ack_tog <= req_s;
endmodule

// File: rtl/mbox_bypass.sv
module mbox_bypass
  import mbox_pkg::*;
#(
  parameter int unsigned W    = MBOX_W_DEF,
  parameter int unsigned SYNC = SYNC_DEF
) (
  input  logic         clk_w,
  input  logic         clk_r,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         mbf_n,
  input  logic         rd_en,
  input  logic         rd_mbsel,
  input  logic [W-1:0] fifo_q,
  output logic         rd_avail,
  output logic [W-1:0] rd_q
);
  logic         req_tog;
  logic         ack_tog;
  logic [W-1:0] word_q;
  rsel_e        rsel;

  mbox_wr_side #(.W(W), .SYNC(SYNC)) u_wr (
    .clk_w(clk_w), .mrst_n(mrst_n), .prst_n(prst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .ack_tog(ack_tog),
    .mbf_n(mbf_n), .req_tog(req_tog), .word_q(word_q)
  );

  mbox_rd_side #(.SYNC(SYNC)) u_rd (
    .clk_r(clk_r), .mrst_n(mrst_n), .prst_n(prst_n),
    .req_tog(req_tog), .rd_en(rd_en), .rd_mbsel(rd_mbsel),
    .rd_avail(rd_avail), .ack_tog(ack_tog)
  );

  assign wr_ready = mbf_n;
  assign rsel     = rsel_e'(rd_mbsel);

  always_comb
    case (rsel)
      RSEL_MBOX: rd_q = word_q;
      default:   rd_q = fifo_q;
    endcase
endmodule

// File: rtl/mbox_bypass_chk.sv
module mbox_bypass_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk_w,
  input logic         clk_r,
  input logic         mrst_n,
  input logic         prst_n,
  input logic         wr_valid,
  input logic         mbf_n,
  input logic         rd_en,
  input logic         rd_mbsel,
  input logic         rd_avail,
  input logic [W-1:0] word_q
);
  // R2
  post_drops_flag_chk: assert property (@(posedge clk_w) disable iff (!mrst_n || !prst_n)
    (wr_valid && mbf_n) |=> !mbf_n);

  // R9
  held_word_stable_chk: assert property (@(posedge clk_w) disable iff (!mrst_n || !prst_n)
    (!mbf_n && !$past(mbf_n)) |-> $stable(word_q));

  // R4
  avail_implies_full_chk: assert property (@(posedge clk_r) disable iff (!mrst_n || !prst_n)
    rd_avail |-> !mbf_n);

  // R5
  take_clears_avail_chk: assert property (@(posedge clk_r) disable iff (!mrst_n || !prst_n)
    (rd_en && rd_mbsel && rd_avail) |=> !rd_avail);

  // R6
  no_take_keeps_avail_chk: assert property (@(posedge clk_r) disable iff (!mrst_n || !prst_n)
    (rd_avail && !(rd_en && rd_mbsel)) |=> rd_avail);
endmodule

bind mbox_bypass mbox_bypass_chk #(.W(W)) u_chk (
  .clk_w(clk_w), .clk_r(clk_r), .mrst_n(mrst_n), .prst_n(prst_n),
  .wr_valid(wr_valid), .mbf_n(mbf_n), .rd_en(rd_en), .rd_mbsel(rd_mbsel),
  .rd_avail(rd_avail), .word_q(word_q)
);

// File: tb/mbox_bypass_tb.sv
module mbox_bypass_tb;
  localparam int CLK_PERIOD   = 10;
  localparam int RCLK_PERIOD  = 14;
  localparam int W            = 36;

  logic clk_w = 0, clk_r = 0;
  logic mrst_n = 0, prst_n = 1;
  logic wr_valid = 0, rd_en = 0, rd_mbsel = 0;
  logic [W-1:0] wr_data = '0, fifo_q = '0;
  logic wr_ready, mbf_n, rd_avail;
  logic [W-1:0] rd_q;

  int n_chk = 0, n_err = 0;
  bit auto_read = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];

  always #(CLK_PERIOD/2)  clk_w = ~clk_w;
  always #(RCLK_PERIOD/2) clk_r = ~clk_r;

  mbox_bypass u_dut (
    .clk_w(clk_w), .clk_r(clk_r), .mrst_n(mrst_n), .prst_n(prst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .mbf_n(mbf_n), .rd_en(rd_en), .rd_mbsel(rd_mbsel), .fifo_q(fifo_q),
    .rd_avail(rd_avail), .rd_q(rd_q)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: posts one word and records it as expected when accepted
  task automatic post(input logic [W-1:0] d);
    @(negedge clk_w);
    while (!wr_ready) @(negedge clk_w);
    wr_valid = 1; wr_data = d;
    @(negedge clk_w);
    wr_valid = 0;
    exp_q.push_back(d);
    check(mbf_n == 1'b0, "R2", W'(mbf_n), W'(0));
  endtask

  task automatic wait_avail(input string req);
    int k = 0;
    while (!rd_avail && k < 5) begin @(negedge clk_r); k++; end
    check(rd_avail == 1'b1 && k <= 4, req, W'(k), W'(4));
  endtask

  // Monitor: takes each word the reader sees and compares it
  initial begin
    forever begin
      @(negedge clk_r);
      if (auto_read && rd_avail) begin
        logic [W-1:0] e;
        rd_mbsel = 1;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
        check(rd_q === e, "R4 scoreboard", rd_q, e);
        rd_en = 1;
        @(negedge clk_r);
        rd_en = 0;
      end
    end
  end

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1 during and after master reset
    rd_mbsel = 1;
    repeat (3) @(negedge clk_w);
    check(mbf_n == 1 && wr_ready == 1 && rd_avail == 0, "R1 in reset", W'({mbf_n, wr_ready, rd_avail}), W'(3'b110));
    mrst_n = 1;
    repeat (3) @(negedge clk_w);
    check(mbf_n == 1 && rd_avail == 0, "R1 after reset", W'({mbf_n, rd_avail}), W'(2'b10));
    check(rd_q == '0, "R1 word cleared", rd_q, '0);

    // R7 FIFO path
    rd_mbsel = 0; fifo_q = 36'h0_DEAD_BEEF; #1;
    check(rd_q == fifo_q, "R7 fifo sel", rd_q, fifo_q);
    fifo_q = 36'hA_5A5A_5A5A; #1;
    check(rd_q == fifo_q, "R7 fifo sel 2", rd_q, fifo_q);

    // R2 post, then R3 ignored offer
    post(36'h1_2345_6789);
    @(negedge clk_w);
    wr_valid = 1; wr_data = 36'hF_FFFF_0000;
    @(negedge clk_w);
    wr_valid = 0;
    check(mbf_n == 0, "R3 flag still low", W'(mbf_n), W'(0));

    // R4 arrival, R7 mailbox sel
    @(negedge clk_r);
    wait_avail("R4 avail");
    rd_mbsel = 1; #1;
    check(rd_q == 36'h1_2345_6789, "R3 word kept", rd_q, 36'h1_2345_6789);
    rd_mbsel = 0; #1;
    check(rd_q == fifo_q, "R7 fifo while held", rd_q, fifo_q);

    // R6 reads that do not take
    rd_en = 1; rd_mbsel = 0; @(negedge clk_r); rd_en = 0;
    check(rd_avail == 1, "R6 mbsel low", W'(rd_avail), W'(1));
    rd_en = 0; rd_mbsel = 1; @(negedge clk_r);
    check(rd_avail == 1 && mbf_n == 0, "R6 rd_en low", W'({rd_avail, mbf_n}), W'(2'b10));

    // R5 take via monitor
    auto_read = 1;
    begin
      int k = 0;
      @(negedge clk_r); @(negedge clk_r);
      check(rd_avail == 0, "R5 avail drop", W'(rd_avail), W'(0));
      @(negedge clk_w);
      while (!mbf_n && k < 5) begin @(negedge clk_w); k++; end
      check(mbf_n == 1 && k <= 4, "R5 flag release", W'(k), W'(4));
    end

    // Streamed words through the scoreboard
    for (int i = 0; i < 6; i++) post(W'(36'h3_0000_0000 + i * 36'h1_1111));
    begin
      int k = 0;
      while (exp_q.size() != 0 && k < 100) begin @(negedge clk_r); k++; end
      check(exp_q.size() == 0, "R5 stream drained", W'(exp_q.size()), W'(0));
    end
    repeat (6) @(negedge clk_w);
    auto_read = 0;

    // R8 partial reset keeps word
    post(36'h7_7777_1234);
    void'(exp_q.pop_back());
    @(negedge clk_r);
    wait_avail("R4 avail before prst");
    prst_n = 0;
    repeat (3) @(negedge clk_w);
    prst_n = 1;
    repeat (2) @(negedge clk_w);
    rd_mbsel = 1; #1;
    check(mbf_n == 1 && rd_avail == 0, "R8 flags", W'({mbf_n, rd_avail}), W'(2'b10));
    check(rd_q == 36'h7_7777_1234, "R8 word kept", rd_q, 36'h7_7777_1234);

    // R1 master reset clears the word
    mrst_n = 0;
    repeat (2) @(negedge clk_w);
    mrst_n = 1;
    @(negedge clk_w); #1;
    check(rd_q == '0, "R1 remaster clears", rd_q, '0);

    done = 1;
    summary();
  end
endmodule